// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors kept in a word-addressed memory and turns each one into bytes on an output stream. Every descriptor occupies `DESC_WORDS` words. Word 0 holds control and status. Word 1 holds the two buffer lengths. Words 2 and 3 hold the byte addresses of buffer 1 and buffer 2. The engine stays idle after reset until software strobes the poll input. It then fetches the descriptor at the current ring position. If the ownership flag is set, it streams the buffer bytes with frame markers and can append a frame check sequence. Finally it writes word 0 back with ownership released and moves on to the next slot.

The end of the ring is a flag inside a descriptor, so the ring can have any number of slots. A frame may span several descriptors. The first-segment and last-segment flags decide where the start and end markers go, and they also decide which bytes the appended CRC covers. When the engine meets a descriptor it does not own, it suspends until the next poll.

Memory port: a request is accepted in any cycle where `mem_req` and `mem_ready` are both high. For a read, `mem_rdata` carries the word in that same cycle. The output stream moves one byte in every cycle where `tx_valid` and `tx_ready` are both high.

Top module: `txr_engine`

## Requirements
- R1: After reset, and until the first poll strobe, the engine makes no memory request, and `tx_valid` stays low.
- R2: A poll strobe makes the engine read word 0 of the descriptor at `ring_base` plus the current ring offset. If bit 31 (ownership) of that word is clear, the engine produces no bytes, makes no write, and makes no further memory request until the next poll.
- R3: For an owned descriptor, the engine sends buffer 1 and then buffer 2. The length of buffer 1 is word 1 bits 12:0, and the length of buffer 2 is word 1 bits 28:16. Their byte addresses are word 2 and word 3. Byte address A is lane A[1:0] (least significant byte first) of memory word A>>2. A buffer of length zero is skipped.
- R4: `tx_sof` marks the first byte sent after a descriptor with bit 28 (first segment) set. `tx_eof` marks the last byte of a descriptor with bit 29 (last segment) set.
- R5: When a descriptor has both bit 29 and bit 25 (append CRC) set, four more bytes follow its data. They carry the inverted reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones) of every data byte sent since the most recent first-segment descriptor, least significant byte first. `tx_eof` then marks the fourth of these bytes.
- R6: After the last byte of a descriptor has been accepted, the engine writes word 0 back to the same address. Bits 31, 0 (underflow), 5 (flushed) and 15 (error summary) are cleared, and every other bit, bit 21 included, is kept. No byte is offered while the write is pending.
- R7: The next descriptor is `DESC_WORDS` words further on. If bit 21 (ring end) of word 0 was set, the next descriptor is at `ring_base` instead.
- R8: While `tx_ready` is low, the offered byte and its markers stay unchanged. While `mem_ready` is low, the pending request stays unchanged. No byte is lost or repeated in either case.
- R9: A poll strobe that arrives while the engine is busy is remembered. After the engine next suspends, it re-reads the descriptor it stopped at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | ADDR_W | Word address of ring slot 0 |
| poll | input | 1 | Poll-demand strobe |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |
| mem_ready | input | 1 | Memory accepts the request |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Byte offered |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
Some properties are checked on every cycle. Stalled stream bytes and stalled memory requests must hold steady. Every write-back must have ownership and the status bits cleared, and no byte may be offered during it. Start markers must alternate properly with end markers, and no byte may appear outside a frame. Other behaviour can only be shown by the bench scenarios, each compared against a byte model of the ring. These are the byte order and lane selection for unaligned buffers, the skipping of empty buffers, the CRC value across multi-descriptor frames, the retention of the ring-end flag, the wrap back to the ring base, suspension on an unowned slot, and the remembered poll.

// File: rtl/txr_pkg.sv
// Shared constants, types and the CRC step function for the transmit ring engine.
package txr_pkg;

    localparam int DATA_W   = 32;
    localparam int LEN_W    = 13;
    localparam int LEN2_LSB = 16;

    // Positions in descriptor word 0
    localparam int OWN_B    = 31;
    localparam int LAST_B   = 29;
    localparam int FIRST_B  = 28;
    localparam int FCS_B    = 25;
    localparam int RING_END_B = 21;
    localparam int ST_ESUM_B  = 15;
    localparam int ST_FLUSH_B = 5;
    localparam int ST_UFL_B   = 0;

    localparam logic [DATA_W-1:0] WB_CLR_MASK =
        (32'h1 << OWN_B) | (32'h1 << ST_ESUM_B) |
        (32'h1 << ST_FLUSH_B) | (32'h1 << ST_UFL_B);

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

    typedef enum logic [2:0] {
        ST_SUSP, ST_RD_CTL, ST_RD_LEN, ST_RD_PTR1,
        ST_RD_PTR2, ST_SEG, ST_FCS, ST_WB
    } txr_state_e;

    typedef enum logic [1:0] {
        W_CTL = 2'd0, W_LEN = 2'd1, W_PTR1 = 2'd2, W_PTR2 = 2'd3
    } txr_word_e;

    // Advance a reflected CRC-32 by one byte
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/txr_crc32.sv
// Frame check accumulator: cleared at a frame start, updated per accepted data byte.
// Assumes clr and upd are never high in the same cycle.
module txr_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    import txr_pkg::*;

    logic [31:0] acc_q;

    // Accumulator register
    always_ff @(posedge clk) begin
        if (!rst_n)   acc_q <= CRC_SEED;
        else if (clr) acc_q <= CRC_SEED;
        else if (upd) acc_q <= crc32_step(acc_q, din);
    end

    assign fcs = ~acc_q;
endmodule

// File: rtl/txr_buf_reader.sv
// Streams one buffer of bytes from word memory. Fetches a word only when no
// fetched bytes remain, and keeps the word until its last needed lane is taken.
// Assumes start is pulsed only while busy is low and start_len is non-zero.
module txr_buf_reader #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 13,
    localparam int BA_W  = ADDR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BA_W-1:0]   start_baddr,
    input  logic [LEN_W-1:0]  start_len,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic              byte_last,
    input  logic              byte_ready,
    output logic              busy
);
    logic [BA_W-1:0]  baddr_q;
    logic [LEN_W-1:0] remain_q;
    logic [31:0]      word_q;
    logic             word_v_q;
    logic [7:0]       lane_byte [4];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign lane_byte[g] = word_q[8*g +: 8];
    end

    // Buffer walk: load, fetch word, hand out lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            baddr_q  <= '0;
            remain_q <= '0;
            word_q   <= '0;
            word_v_q <= 1'b0;
        end else if (start) begin
            busy     <= 1'b1;
            baddr_q  <= start_baddr;
            remain_q <= start_len;
            word_v_q <= 1'b0;
        end else if (busy) begin
            if (!word_v_q) begin
                if (mem_ready) begin
                    word_q   <= mem_rdata;
                    word_v_q <= 1'b1;
                end
            end else if (byte_ready) begin
                baddr_q  <= baddr_q + 1'b1;
                remain_q <= remain_q - 1'b1;
                if (baddr_q[1:0] == 2'd3 || byte_last) word_v_q <= 1'b0;
                if (byte_last) busy <= 1'b0;
            end
        end
    end

    assign mem_req    = busy && !word_v_q;
    assign mem_addr   = baddr_q[BA_W-1:2];
    assign byte_valid = busy && word_v_q;
    assign byte_data  = lane_byte[baddr_q[1:0]];
    assign byte_last  = (remain_q == LEN_W'(1));
endmodule

// File: rtl/txr_desc_fsm.sv
// Descriptor sequencer: poll handling, descriptor fetch, buffer hand-off,
// CRC byte phase, status write-back and ring advance.
// Assumes the buffer reader is idle whenever the state is not ST_SEG.
module txr_desc_fsm #(
    parameter int ADDR_W     = 16,
    parameter int DESC_WORDS = 8,
    localparam int BA_W      = ADDR_W + 2,
    localparam int LEN_W     = txr_pkg::LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              poll,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              desc_req,
    output logic              desc_we,
    output logic [ADDR_W-1:0] desc_addr,
    output logic [31:0]       desc_wdata,
    output logic              rd_start,
    output logic [BA_W-1:0]   rd_baddr,
    output logic [LEN_W-1:0]  rd_len,
    input  logic              rd_done,
    input  logic              tx_hs,
    output logic              in_data,
    output logic              in_fcs,
    output logic [1:0]        fcs_idx,
    output logic              sof_pend,
    output logic              final_data,
    output logic              crc_clr
);
    import txr_pkg::*;

    txr_state_e        state_q;
    logic [ADDR_W-1:0] off_q;
    logic [31:0]       ctl_q;
    logic [LEN_W-1:0]  len1_q, len2_q;
    logic [BA_W-1:0]   ptr1_q, ptr2_q;
    logic              seg_q, started_q, poll_pend_q;
    txr_word_e         widx;
    logic              advance;

    // Which descriptor word the current state accesses
    always_comb begin
        unique case (state_q)
            ST_RD_LEN:  widx = W_LEN;
            ST_RD_PTR1: widx = W_PTR1;
            ST_RD_PTR2: widx = W_PTR2;
            default:    widx = W_CTL;
        endcase
    end

    // Memory-side outputs of the sequencer
    always_comb begin
        desc_req   = (state_q == ST_RD_CTL) || (state_q == ST_RD_LEN) ||
                     (state_q == ST_RD_PTR1) || (state_q == ST_RD_PTR2) ||
                     (state_q == ST_WB);
        desc_we    = (state_q == ST_WB);
        desc_addr  = ring_base + off_q + ADDR_W'(widx);
        desc_wdata = ctl_q & ~WB_CLR_MASK;
    end

    // Buffer hand-off and stream control
    always_comb begin
        rd_len     = seg_q ? len2_q : len1_q;
        rd_baddr   = seg_q ? ptr2_q : ptr1_q;
        in_data    = (state_q == ST_SEG);
        in_fcs     = (state_q == ST_FCS);
        rd_start   = in_data && !started_q && (rd_len != '0);
        advance    = in_data && ((!started_q && rd_len == '0) || rd_done);
        final_data = ctl_q[LAST_B] && !ctl_q[FCS_B] && (seg_q || len2_q == '0);
        crc_clr    = (state_q == ST_RD_CTL) && mem_ready &&
                     mem_rdata[OWN_B] && mem_rdata[FIRST_B];
    end

    // Remembered poll demand
    always_ff @(posedge clk) begin
        if (!rst_n) poll_pend_q <= 1'b0;
        else        poll_pend_q <= poll || (poll_pend_q && state_q != ST_SUSP);
    end

    // Main sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_SUSP;
            off_q     <= '0;
            ctl_q     <= '0;
            len1_q    <= '0;
            len2_q    <= '0;
            ptr1_q    <= '0;
            ptr2_q    <= '0;
            seg_q     <= 1'b0;
            started_q <= 1'b0;
            sof_pend  <= 1'b0;
            fcs_idx   <= '0;
        end else begin
            if (tx_hs) sof_pend <= 1'b0;
            unique case (state_q)
                ST_SUSP: if (poll_pend_q) state_q <= ST_RD_CTL;
                ST_RD_CTL: if (mem_ready) begin
                    ctl_q   <= mem_rdata;
                    state_q <= mem_rdata[OWN_B] ? ST_RD_LEN : ST_SUSP;
                    if (mem_rdata[OWN_B] && mem_rdata[FIRST_B]) sof_pend <= 1'b1;
                end
                ST_RD_LEN: if (mem_ready) begin
                    len1_q  <= mem_rdata[LEN_W-1:0];
                    len2_q  <= mem_rdata[LEN2_LSB +: LEN_W];
                    state_q <= ST_RD_PTR1;
                end
                ST_RD_PTR1: if (mem_ready) begin
                    ptr1_q  <= mem_rdata[BA_W-1:0];
                    state_q <= ST_RD_PTR2;
                end
                ST_RD_PTR2: if (mem_ready) begin
                    ptr2_q    <= mem_rdata[BA_W-1:0];
                    seg_q     <= 1'b0;
                    started_q <= 1'b0;
                    state_q   <= ST_SEG;
                end
                ST_SEG: begin
                    if (rd_start) started_q <= 1'b1;
                    if (advance) begin
                        if (!seg_q) begin
                            seg_q     <= 1'b1;
                            started_q <= 1'b0;
                        end else begin
                            fcs_idx <= '0;
                            state_q <= (ctl_q[LAST_B] && ctl_q[FCS_B]) ? ST_FCS : ST_WB;
                        end
                    end
                end
                ST_FCS: if (tx_hs) begin
                    fcs_idx <= fcs_idx + 1'b1;
                    if (fcs_idx == 2'd3) state_q <= ST_WB;
                end
                ST_WB: if (mem_ready) begin
                    off_q   <= ctl_q[RING_END_B] ? '0 : off_q + ADDR_W'(DESC_WORDS);
                    state_q <= ST_RD_CTL;
                end
                default: state_q <= ST_SUSP;
            endcase
        end
    end
endmodule

// File: rtl/txr_engine.sv
// Transmit descriptor ring engine top: joins the sequencer, the buffer reader
// and the CRC accumulator, shares one memory port and forms the byte stream.
// Assumes DESC_WORDS >= 4 and that the sink and memory obey valid/ready rules.
module txr_engine #(
    parameter int ADDR_W     = 16,
    parameter int DESC_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              poll,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_sof,
    output logic              tx_eof,
    input  logic              tx_ready
);
    localparam int BA_W  = ADDR_W + 2;
    localparam int LEN_W = txr_pkg::LEN_W;

    logic              desc_req, desc_we;
    logic [ADDR_W-1:0] desc_addr;
    logic [31:0]       desc_wdata;
    logic              rd_start, rd_done, rd_busy;
    logic [BA_W-1:0]   rd_baddr;
    logic [LEN_W-1:0]  rd_len;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_valid, rd_last;
    logic [7:0]        rd_byte;
    logic              in_data, in_fcs, sof_pend, final_data, crc_clr;
    logic [1:0]        fcs_idx;
    logic [31:0]       fcs;
    logic              tx_hs, data_hs;

    txr_desc_fsm #(.ADDR_W(ADDR_W), .DESC_WORDS(DESC_WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll(poll),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .desc_req(desc_req), .desc_we(desc_we), .desc_addr(desc_addr),
        .desc_wdata(desc_wdata), .rd_start(rd_start), .rd_baddr(rd_baddr),
        .rd_len(rd_len), .rd_done(rd_done), .tx_hs(tx_hs),
        .in_data(in_data), .in_fcs(in_fcs), .fcs_idx(fcs_idx),
        .sof_pend(sof_pend), .final_data(final_data), .crc_clr(crc_clr)
    );

    txr_buf_reader #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rdr (
        .clk(clk), .rst_n(rst_n), .start(rd_start), .start_baddr(rd_baddr),
        .start_len(rd_len), .mem_req(rd_req), .mem_addr(rd_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .byte_valid(rd_valid), .byte_data(rd_byte), .byte_last(rd_last),
        .byte_ready(in_data && tx_ready), .busy(rd_busy)
    );

    txr_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(data_hs),
        .din(rd_byte), .fcs(fcs)
    );

    // Memory port sharing: the reader is only active during buffer phases
    always_comb begin
        mem_req   = desc_req || rd_req;
        mem_we    = desc_we && !rd_req;
        mem_addr  = rd_req ? rd_addr : desc_addr;
        mem_wdata = desc_wdata;
    end

    // Output stream formation
    always_comb begin
        tx_valid = (in_data && rd_valid && rd_busy) || in_fcs;
        tx_data  = in_fcs ? fcs[8*fcs_idx +: 8] : rd_byte;
        tx_sof   = tx_valid && sof_pend;
        tx_eof   = tx_valid && (in_fcs ? (fcs_idx == 2'd3) : (rd_last && final_data));
        tx_hs    = tx_valid && tx_ready;
        data_hs  = tx_hs && in_data;
        rd_done  = data_hs && rd_last;
    end
endmodule

// File: rtl/txr_engine_chk.sv
// Protocol checker for txr_engine, attached by bind.
module txr_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ready,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_sof,
    input logic              tx_eof,
    input logic              tx_ready
);
    logic in_frame_q;

    // Track whether a frame has started and not yet ended
    always_ff @(posedge clk) begin
        if (!rst_n) in_frame_q <= 1'b0;
        else if (tx_valid && tx_ready) begin
            if (tx_eof)      in_frame_q <= 1'b0;
            else if (tx_sof) in_frame_q <= 1'b1;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !tx_valid));

    a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=>
        (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)));

    a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r6_wb_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |->
        (!mem_wdata[31] && !mem_wdata[15] && !mem_wdata[5] && !mem_wdata[0]));

    a_r6_no_byte_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !tx_valid);

    a_r4_sof_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sof) |-> !in_frame_q);

    a_r4_byte_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_sof) |-> in_frame_q);
endmodule

bind txr_engine txr_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .tx_ready(tx_ready)
);

// File: tb/txr_engine_bench.sv
module txr_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 12;
    localparam int DESC_W     = 8;
    localparam logic [AW-1:0] RING = 12'h100;
    localparam logic [31:0] OWN = 32'h8000_0000, LS = 32'h2000_0000, FS = 32'h1000_0000;
    localparam logic [31:0] FCS = 32'h0200_0000, REND = 32'h0020_0000;
    localparam logic [31:0] CLRM = 32'h8000_8021;

    logic clk = 1'b0, rst_n = 1'b0, poll = 1'b0;
    logic [AW-1:0] ring_base = RING;
    logic mem_req, mem_we, mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [7:0] tx_data;
    logic tx_valid, tx_sof, tx_eof, tx_ready = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txr_engine #(.ADDR_W(AW), .DESC_WORDS(DESC_W)) u_txr_engine (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll(poll),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof),
        .tx_eof(tx_eof), .tx_ready(tx_ready)
    );

    logic [31:0] mem [0:4095];
    assign mem_rdata = mem[mem_addr];

    int n_chk = 0, n_fail = 0;
    int cap_n, wr_cnt, rd_any, exp_n;
    int rd_at [0:4095];
    logic [7:0] cap_b [0:4095];
    logic       cap_s [0:4095], cap_e [0:4095];
    logic [7:0] exp_b [0:4095];
    logic       exp_s [0:4095], exp_e [0:4095];
    int stall_mem = 0, stall_tx = 0, cur_slot = 0;
    logic [31:0] d_w0 [4];
    int d_s1 [4], d_s2 [4], d_a1 [4], d_a2 [4], d_slot [4];
    bit d_end [4];

    // Random ready levels, driven on the falling edge
    always @(negedge clk) begin
        mem_ready = (($urandom % 100) >= stall_mem);
        tx_ready  = (($urandom % 100) >= stall_tx);
    end

    // Sampler: records accepted bytes and memory traffic between edges
    initial forever begin
        @(negedge clk);
        #3;
        if (rst_n) begin
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    rd_at[mem_addr]++;
                    rd_any++;
                end
            end
            if (tx_valid && tx_ready && cap_n < 4096) begin
                cap_b[cap_n] = tx_data;
                cap_s[cap_n] = tx_sof;
                cap_e[cap_n] = tx_eof;
                cap_n++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int j = 0; j < 8; j++) begin
            logic fb = r[0] ^ b[j];
            r = r >> 1;
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    function automatic logic [7:0] byte_at(input int ba);
        logic [31:0] w = mem[ba >> 2];
        return w[8*(ba % 4) +: 8];
    endfunction

    task automatic build_expected(input int n);
        logic [31:0] crc = 32'hFFFFFFFF;
        bit sofp = 0;
        exp_n = 0;
        for (int i = 0; i < n; i++) begin
            int tot = d_s1[i] + d_s2[i];
            int k = 0;
            if (d_w0[i] & FS) begin crc = 32'hFFFFFFFF; sofp = 1; end
            for (int sg = 0; sg < 2; sg++) begin
                int len = sg ? d_s2[i] : d_s1[i];
                int a   = sg ? d_a2[i] : d_a1[i];
                for (int j = 0; j < len; j++) begin
                    logic [7:0] b = byte_at(a + j);
                    crc = crc_ref(crc, b);
                    k++;
                    exp_b[exp_n] = b;
                    exp_s[exp_n] = sofp;
                    sofp = 0;
                    exp_e[exp_n] = ((d_w0[i] & LS) != 0) && ((d_w0[i] & FCS) == 0) && (k == tot);
                    exp_n++;
                end
            end
            if ((d_w0[i] & LS) && (d_w0[i] & FCS)) begin
                logic [31:0] fin = ~crc;
                for (int j = 0; j < 4; j++) begin
                    exp_b[exp_n] = fin[8*j +: 8];
                    exp_s[exp_n] = sofp;
                    sofp = 0;
                    exp_e[exp_n] = (j == 3);
                    exp_n++;
                end
            end
        end
    endtask

    task automatic pulse_poll();
        @(negedge clk); poll = 1'b1;
        @(negedge clk); poll = 1'b0;
    endtask

    // Lay out n descriptors from the current slot, run them and compare
    task automatic run_batch(input int n, input bit mid_poll, input string tag);
        int s = cur_slot;
        int nxt, t, need;
        for (int i = 0; i < n; i++) begin
            d_slot[i] = s;
            if (s == 15 || (d_end[i] && s >= 4)) d_w0[i] = d_w0[i] | REND;
            else d_w0[i] = d_w0[i] & ~REND;
            mem[RING + s*DESC_W + 0] = d_w0[i];
            mem[RING + s*DESC_W + 1] = (d_s2[i] << 16) | d_s1[i];
            mem[RING + s*DESC_W + 2] = d_a1[i];
            mem[RING + s*DESC_W + 3] = d_a2[i];
            s = (d_w0[i] & REND) ? 0 : s + 1;
        end
        nxt = s;
        mem[RING + nxt*DESC_W] = 32'h0;
        build_expected(n);
        cap_n = 0; wr_cnt = 0; rd_any = 0;
        for (int a = 0; a < 4096; a++) rd_at[a] = 0;
        need = mid_poll ? 2 : 1;
        pulse_poll();
        if (mid_poll) begin
            t = 0;
            while (cap_n < 1 && t < 20000) begin @(negedge clk); t++; end
            pulse_poll();
        end
        t = 0;
        while (!(cap_n >= exp_n && wr_cnt >= n && rd_at[RING + nxt*DESC_W] >= need) && t < 20000) begin
            @(negedge clk); t++;
        end
        check(t < 20000, {tag, " R8 completion"}, t, 20000);
        repeat (40) @(negedge clk);
        check(cap_n == exp_n, {tag, " R3 byte count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            check(cap_b[i] == exp_b[i], {tag, " R3 R5 byte"}, cap_b[i], exp_b[i]);
            check(cap_s[i] == exp_s[i] && cap_e[i] == exp_e[i], {tag, " R4 markers"},
                  {cap_s[i], cap_e[i]}, {exp_s[i], exp_e[i]});
        end
        for (int i = 0; i < n; i++)
            check(mem[RING + d_slot[i]*DESC_W] == (d_w0[i] & ~CLRM), {tag, " R6 write-back"},
                  mem[RING + d_slot[i]*DESC_W], d_w0[i] & ~CLRM);
        check(wr_cnt == n, {tag, " R6 write count"}, wr_cnt, n);
        check(rd_at[RING + nxt*DESC_W] == need, {tag, " R2 R7 R9 next slot reads"},
              rd_at[RING + nxt*DESC_W], need);
        cur_slot = nxt;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int a = 0; a < 4096; a++) mem[a] = (a >= 12'h400) ? $urandom : 32'h0;
        for (int a = 0; a < 4096; a++) rd_at[a] = 0;
        cap_n = 0; wr_cnt = 0; rd_any = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #3;
        check(!tx_valid && !mem_req, "R1 reset outputs", {tx_valid, mem_req}, 0);
        repeat (20) @(negedge clk);
        check(rd_any == 0 && wr_cnt == 0 && cap_n == 0, "R1 idle without poll", rd_any, 0);

        // R2: unowned slot 0
        run_batch(0, 0, "T1 R2");

        // Single aligned frame with CRC; status bits preset, spare bits kept (R6)
        d_w0[0] = OWN | FS | LS | FCS | 32'h0040_8021; d_s1[0] = 17; d_s2[0] = 0;
        d_a1[0] = 'h1000; d_a2[0] = 'h2000; d_end[0] = 0;
        run_batch(1, 0, "T2 R5");

        // Two buffers at unaligned addresses, stalls on both sides (R3 R8)
        stall_mem = 30; stall_tx = 30;
        d_w0[0] = OWN | FS | LS; d_s1[0] = 6; d_s2[0] = 9;
        d_a1[0] = 'h1203; d_a2[0] = 'h1402; d_end[0] = 0;
        run_batch(1, 0, "T3 R3");

        // Frame over two descriptors, empty buffer 1 in the second (R3 R5)
        d_w0[0] = OWN | FS; d_s1[0] = 5; d_s2[0] = 3; d_a1[0] = 'h1501; d_a2[0] = 'h1600; d_end[0] = 0;
        d_w0[1] = OWN | LS | FCS; d_s1[1] = 0; d_s2[1] = 7; d_a1[1] = 'h1700; d_a2[1] = 'h1803; d_end[1] = 0;
        run_batch(2, 0, "T4 R5");

        // Ring end at slot 5 wraps to the base (R7)
        d_w0[0] = OWN | FS | LS; d_s1[0] = 4; d_s2[0] = 0; d_a1[0] = 'h1900; d_a2[0] = 0; d_end[0] = 0;
        d_w0[1] = OWN | FS | LS | FCS; d_s1[1] = 3; d_s2[1] = 2; d_a1[1] = 'h1A02; d_a2[1] = 'h1B01; d_end[1] = 1;
        run_batch(2, 0, "T5 R7");
        check(cur_slot == 0 && rd_at[RING + 6*DESC_W] == 0, "T5 R7 wrap skips slot 6",
              rd_at[RING + 6*DESC_W], 0);

        // Poll during a busy frame is remembered (R9)
        stall_tx = 50;
        d_w0[0] = OWN | FS | LS; d_s1[0] = 40; d_s2[0] = 40; d_a1[0] = 'h1C00; d_a2[0] = 'h1D01; d_end[0] = 0;
        run_batch(1, 1, "T6 R9");

        // Random frames, stalls and ring ends
        for (int it = 0; it < 25; it++) begin
            int n = 1 + ($urandom % 3);
            stall_mem = $urandom % 60;
            stall_tx  = $urandom % 60;
            for (int i = 0; i < n; i++) begin
                bit fcs = (i == n-1) && ($urandom % 2);
                d_w0[i] = OWN | ((i == 0) ? FS : 0) | ((i == n-1) ? LS : 0) | (fcs ? FCS : 0)
                        | ($urandom & 32'h0C4F_7FDE);
                d_s1[i] = $urandom % 41;
                d_s2[i] = (($urandom % 10) < 3) ? 0 : $urandom % 41;
                if (i == n-1 && !fcs && d_s1[i] == 0) d_s1[i] = 1;
                d_a1[i] = 'h1000 + ($urandom % 'h2F00);
                d_a2[i] = 'h1000 + ($urandom % 'h2F00);
                d_end[i] = (($urandom % 5) == 0);
            end
            run_batch(n, 0, "T7 R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule